// File: doc/BRIEF.md
# PWM Compare Channel with Shadowed Threshold

This block is a single compare channel of a general-purpose timer. It watches the shared count that an external counter produces, compares it against a private threshold register and shapes a PWM level from the result. Two waveform styles are supported: a sawtooth style, where the level rises at the count's upper limit and falls on a match, and a triangle style, where the count ramps up and back down and the direction of travel at the match decides whether the level rises or falls.

The threshold is double-buffered. Software writes a shadow copy. The live threshold takes that copy only when the counter signals an update event, so a new duty cycle never starts in the middle of a period. When the channel is switched off, or the timer is not in compare operation, the output goes to a per-channel default level. The output-enable simply follows the timer enable. All events are taken only on prescaler ticks, which is the last clock of each count value, so each count value gives at most one match.

Top module: `pwm_cmp_channel`

## Requirements
- R1: Sawtooth mode (`dual_slope_i`=0, channel active): after a cycle with `tick_i`=1 and `at_top_i`=1 the level is 1. After a cycle with `tick_i`=1 and `count_i` equal to the threshold it is 0. If both occur in the same cycle, the top event wins. With an up-counter wrapping from PER to 0 and a prescale of PRES, the level is high for (threshold+1)*(PRES+1) clocks out of every (PER+1)*(PRES+1).
- R2: Triangle mode (`dual_slope_i`=1, channel active): after a tick at a threshold match, the level becomes 0 if `count_down_i`=0 and 1 if `count_down_i`=1. Otherwise, after a tick with `at_bottom_i`=1, it becomes 1. For a threshold strictly between 0 and PER, the level is high for 2*threshold*(PRES+1) clocks per period.
- R3: `match_o` pulses for exactly one cycle, in the cycle after a tick where the channel is active and `count_i` equals the live threshold. It is 0 at all other times.
- R4: A cycle with `shadow_wr_i`=1 stores `shadow_wdata_i` and makes `shadow_valid_o` 1 from the next cycle.
- R5: `update_i` with the shadow valid copies the shadow into the live threshold (`cmp_val_o`) and clears `shadow_valid_o` in the next cycle. `update_i` with the shadow not valid leaves the threshold unchanged. The threshold changes at no other time.
- R6: If a shadow write and an update fall in the same cycle, the threshold takes the previous shadow value (when it was valid), the shadow takes the new data, and `shadow_valid_o` stays 1.
- R7: The channel is active when `ch_en_i`=1 and `cmp_mode_i`=1. In the cycle after an inactive cycle, `pwm_o` equals `def_level_i` and no match is flagged. After reactivation, the level starts from the default and holds it until the next event.
- R8: `pwm_oe_o` equals `tmr_en_i` delayed by one clock.
- R9: While `rst_ni` is low: `pwm_o` equals `def_level_i`, and `pwm_oe_o`, `match_o` and `shadow_valid_o` are 0. After reset, `cmp_val_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmr_en_i | input | 1 | Timer enable, drives the output enable |
| cmp_mode_i | input | 1 | Timer is in compare (waveform) operation |
| ch_en_i | input | 1 | Channel enable |
| dual_slope_i | input | 1 | 0 sawtooth, 1 triangle |
| def_level_i | input | 1 | Output level while inactive |
| count_i | input | CNT_W | Shared count value |
| count_down_i | input | 1 | Count is currently decrementing |
| tick_i | input | 1 | Prescaler tick: last clock of the current count value |
| at_top_i | input | 1 | Count equals the period limit |
| at_bottom_i | input | 1 | Count equals zero |
| update_i | input | 1 | Update event |
| shadow_wr_i | input | 1 | Write strobe for the shadow threshold |
| shadow_wdata_i | input | CNT_W | Shadow write data |
| pwm_o | output | 1 | PWM level |
| pwm_oe_o | output | 1 | PWM output enable |
| match_o | output | 1 | Compare match event pulse |
| shadow_valid_o | output | 1 | Shadow holds a value not yet applied |
| cmp_val_o | output | CNT_W | Live threshold |

## Verification
On every cycle, the assertions check the local cause-and-effect rules: a match only follows an active tick; a top tick in sawtooth mode and an up-count match in triangle mode set the level they should; valid set on write and cleared on update; the threshold holding between updates; the default level after inactivity; and the output enable tracking the timer enable. Duty-cycle length over full periods, the ordering of a write and an update in the same cycle, reactivation from the default level, and the reset values can only be shown by the bench's scenarios. The bench drives its own counter and compares against a cycle model and against closed-form duty counts.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;

  // events seen by the waveform shaper in one cycle
  typedef struct packed {
    logic tick;
    logic hit;
    logic top;
    logic bottom;
    logic down;
  } cmp_evt_t;

  typedef enum logic {
    SLOPE_SAW = 1'b0,
    SLOPE_TRI = 1'b1
  } slope_e;

endpackage

// File: rtl/cmp_shadow_reg.sv
module cmp_shadow_reg #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             update_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             valid_o
);

  logic [CNT_W-1:0] shadow_q;
  logic             load;

  assign load = update_i & valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      cmp_o    <= '0;
      valid_o  <= 1'b0;
    end else begin
      if (load) cmp_o <= shadow_q;
      if (wr_i) begin
        shadow_q <= wdata_i;
        valid_o  <= 1'b1;
      end else if (load) begin
        valid_o  <= 1'b0;
      end
    end
  end

  AST_WRITE_SETS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> valid_o); // R4
  AST_UPDATE_CLEARS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_i && !wr_i) |=> !valid_o); // R5
  AST_CMP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(update_i && valid_o) |=> $stable(cmp_o)); // R5
  AST_CMP_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_i && valid_o) |=> (cmp_o == $past(shadow_q))); // R6

endmodule

// File: rtl/cmp_match_unit.sv
module cmp_match_unit #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             hit_o,
  output logic             match_o
);

  // only the last clock of a count value may match
  assign hit_o = active_i & tick_i & (count_i == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_o <= 1'b0;
    else         match_o <= hit_o;
  end

  AST_MATCH_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(tick_i && active_i)); // R3
  AST_MATCH_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !$past(tick_i, 2)) |-> !$past(match_o)); // R3

endmodule

// File: rtl/pwm_wave_gen.sv
module pwm_wave_gen
  import pwm_cmp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     active_i,
  input  slope_e   slope_i,
  input  cmp_evt_t evt_i,
  input  logic     def_i,
  output logic     wave_o
);

  logic wave_d;

  always_comb begin
    wave_d = wave_o;
    if (!active_i) begin
      wave_d = def_i;
    end else if (slope_i == SLOPE_TRI) begin
      if (evt_i.hit)                      wave_d = evt_i.down;
      else if (evt_i.tick && evt_i.bottom) wave_d = 1'b1;
    end else begin
      if (evt_i.tick && evt_i.top) wave_d = 1'b1;
      else if (evt_i.hit)          wave_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wave_o <= 1'b0;
    else         wave_o <= wave_d;
  end

  AST_SAW_TOP_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && slope_i == SLOPE_SAW && evt_i.tick && evt_i.top) |=> wave_o); // R1
  AST_TRI_UP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && slope_i == SLOPE_TRI && evt_i.hit && !evt_i.down) |=> !wave_o); // R2
  AST_TRI_DOWN_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && slope_i == SLOPE_TRI && evt_i.hit && evt_i.down) |=> wave_o); // R2

endmodule

// File: rtl/pwm_cmp_channel.sv
module pwm_cmp_channel
  import pwm_cmp_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tmr_en_i,
  input  logic             cmp_mode_i,
  input  logic             ch_en_i,
  input  logic             dual_slope_i,
  input  logic             def_level_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             count_down_i,
  input  logic             tick_i,
  input  logic             at_top_i,
  input  logic             at_bottom_i,
  input  logic             update_i,
  input  logic             shadow_wr_i,
  input  logic [CNT_W-1:0] shadow_wdata_i,
  output logic             pwm_o,
  output logic             pwm_oe_o,
  output logic             match_o,
  output logic             shadow_valid_o,
  output logic [CNT_W-1:0] cmp_val_o
);

  logic     active;
  logic     active_q;
  logic     hit;
  logic     wave;
  cmp_evt_t evt;
  slope_e   slope;

  assign active = ch_en_i & cmp_mode_i;
  assign slope  = dual_slope_i ? SLOPE_TRI : SLOPE_SAW;

  cmp_shadow_reg #(.CNT_W(CNT_W)) u_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (shadow_wr_i),
    .wdata_i  (shadow_wdata_i),
    .update_i (update_i),
    .cmp_o    (cmp_val_o),
    .valid_o  (shadow_valid_o)
  );

  cmp_match_unit #(.CNT_W(CNT_W)) u_match (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .tick_i   (tick_i),
    .count_i  (count_i),
    .cmp_i    (cmp_val_o),
    .hit_o    (hit),
    .match_o  (match_o)
  );

  assign evt = '{tick: tick_i, hit: hit, top: at_top_i,
                 bottom: at_bottom_i, down: count_down_i};

  pwm_wave_gen u_wave (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .slope_i  (slope),
    .evt_i    (evt),
    .def_i    (def_level_i),
    .wave_o   (wave)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      pwm_oe_o <= 1'b0;
    end else begin
      active_q <= active;
      pwm_oe_o <= tmr_en_i;
    end
  end

  assign pwm_o = active_q ? wave : def_level_i;

  AST_OE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_en_i |=> pwm_oe_o); // R8
  AST_OE_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmr_en_i |=> !pwm_oe_o); // R8
  AST_IDLE_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ch_en_i && cmp_mode_i) |=> (pwm_o == def_level_i && !match_o)); // R7

endmodule

// File: tb/pwm_cmp_channel_tb.sv
module pwm_cmp_channel_tb;
  localparam int CW = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tmr_en_i = 1'b0, cmp_mode_i = 1'b0, ch_en_i = 1'b0, dual_slope_i = 1'b0;
  logic def_level_i = 1'b1, count_down_i = 1'b0, tick_i = 1'b0;
  logic at_top_i = 1'b0, at_bottom_i = 1'b0, update_i = 1'b0, shadow_wr_i = 1'b0;
  logic [CW-1:0] count_i = '0, shadow_wdata_i = '0;
  logic pwm_o, pwm_oe_o, match_o, shadow_valid_o;
  logic [CW-1:0] cmp_val_o;

  always #4 clk_i = ~clk_i;

  pwm_cmp_channel #(.CNT_W(CW)) u_dut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench counter: mode 0 saw up, 1 saw down, 2 triangle
  int mode = 0, per = 9, pres = 0, pc = 0;
  bit run = 0, dn = 0, wr_req = 0, upd_req = 0;
  logic [CW-1:0] cnt = '0, wr_val = '0;

  // cycle model state
  logic [CW-1:0] m_cmp = '0, m_sh = '0;
  logic m_v = 0, m_wave = 0, m_actq = 0, m_match = 0, m_oe = 0, m_tri = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    logic act, hit, n_wave;
    tick_i       = run && (pc == pres);
    count_i      = cnt;
    count_down_i = (mode == 1) || (mode == 2 && dn);
    at_top_i     = (cnt == CW'(per));
    at_bottom_i  = (cnt == '0);
    dual_slope_i = (mode == 2);
    update_i     = upd_req || (tick_i && ((mode == 0) ? at_top_i : at_bottom_i));
    shadow_wr_i  = wr_req;
    shadow_wdata_i = wr_val;
    // model
    act = ch_en_i & cmp_mode_i;
    hit = act & tick_i & (count_i == m_cmp);
    n_wave = m_wave;
    if (!act) n_wave = def_level_i;
    else if (mode == 2) begin
      if (hit) n_wave = count_down_i;
      else if (tick_i && at_bottom_i) n_wave = 1'b1;
    end else begin
      if (tick_i && at_top_i) n_wave = 1'b1;
      else if (hit) n_wave = 1'b0;
    end
    if (update_i && m_v) m_cmp = m_sh;
    if (wr_req) begin m_sh = wr_val; m_v = 1'b1; end
    else if (update_i && m_v) m_v = 1'b0;
    m_wave = n_wave; m_match = hit; m_actq = act; m_oe = tmr_en_i; m_tri = (mode == 2);
    @(posedge clk_i);
    @(negedge clk_i);
    wr_req = 0; upd_req = 0;
    if (tick_i) begin
      pc = 0;
      case (mode)
        0: cnt = (cnt == CW'(per)) ? '0 : cnt + 1'b1;
        1: cnt = (cnt == '0) ? CW'(per) : cnt - 1'b1;
        default: begin
          if (!dn) begin
            if (cnt == CW'(per)) begin dn = 1; cnt = cnt - 1'b1; end
            else cnt = cnt + 1'b1;
          end else begin
            if (cnt == '0) begin dn = 0; cnt = cnt + 1'b1; end
            else cnt = cnt - 1'b1;
          end
        end
      endcase
    end else if (run) pc++;
    chk(pwm_o == (m_actq ? m_wave : def_level_i), !m_actq ? "R7" : (m_tri ? "R2" : "R1"),
        pwm_o, m_actq ? m_wave : def_level_i);
    chk(match_o == m_match, "R3", match_o, m_match);
    chk(shadow_valid_o == m_v, "R4", shadow_valid_o, m_v);
    chk(cmp_val_o == m_cmp, "R5", cmp_val_o, m_cmp);
    chk(pwm_oe_o == m_oe, "R8", pwm_oe_o, m_oe);
  endtask

  task automatic restart(input int md, input int p, input int ps);
    mode = md; per = p; pres = ps; pc = 0; dn = 0;
    cnt = (md == 1) ? CW'(p) : '0;
  endtask

  task automatic load_cmp(input int v);
    wr_req = 1; wr_val = CW'(v); step();
    upd_req = 1; step();
  endtask

  task automatic duty(input int cycles, input int exp, input string req);
    int hi = 0;
    for (int i = 0; i < cycles; i++) begin step(); hi += int'(pwm_o); end
    chk(hi == exp, req, hi, exp);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2718);
    // R9 reset values
    tmr_en_i = 1; ch_en_i = 1; cmp_mode_i = 1;
    #20;
    chk(pwm_o == 1'b1, "R9", pwm_o, 1);
    chk(pwm_oe_o == 1'b0, "R9", pwm_oe_o, 0);
    chk(match_o == 1'b0, "R9", match_o, 0);
    chk(shadow_valid_o == 1'b0, "R9", shadow_valid_o, 0);
    @(negedge clk_i); rst_ni = 1;
    chk(cmp_val_o == '0, "R9", cmp_val_o, 0);
    def_level_i = 0;

    // R6: write and update together, counter halted
    run = 0; restart(0, 9, 0);
    wr_req = 1; wr_val = 16'd5; step();
    wr_req = 1; wr_val = 16'd7; upd_req = 1; step();
    chk(cmp_val_o == 16'd5, "R6", cmp_val_o, 5);
    chk(shadow_valid_o == 1'b1, "R6", shadow_valid_o, 1);
    upd_req = 1; step();
    chk(cmp_val_o == 16'd7, "R5", cmp_val_o, 7);
    upd_req = 1; step();
    chk(cmp_val_o == 16'd7, "R5", cmp_val_o, 7);

    // R1 sawtooth duty: per 9, pres 2, thr 3 -> 12 high of 30
    restart(0, 9, 2); load_cmp(3); run = 1;
    for (int i = 0; i < 60; i++) step();
    duty(60, 24, "R1");

    // R2 triangle duty: per 9, pres 1, thr 4 -> 16 high of 36
    run = 0; restart(2, 9, 1); load_cmp(4); run = 1;
    for (int i = 0; i < 72; i++) step();
    duty(72, 32, "R2");

    // R7 inactive with default high, then reactivation holds default
    def_level_i = 1; ch_en_i = 0;
    for (int i = 0; i < 20; i++) step();
    chk(pwm_o == 1'b1, "R7", pwm_o, 1);
    run = 0; ch_en_i = 1; step(); step();
    chk(pwm_o == 1'b1, "R7", pwm_o, 1);
    cmp_mode_i = 0; run = 1; def_level_i = 0;
    for (int i = 0; i < 10; i++) step();
    chk(pwm_o == 1'b0, "R7", pwm_o, 0);
    cmp_mode_i = 1;

    // R8 enable toggle
    tmr_en_i = 0; step();
    chk(pwm_oe_o == 1'b0, "R8", pwm_oe_o, 0);
    tmr_en_i = 1; step();
    chk(pwm_oe_o == 1'b1, "R8", pwm_oe_o, 1);

    // random segments
    for (int s = 0; s < 12; s++) begin
      restart(int'($urandom % 3), 3 + int'($urandom % 10), int'($urandom % 4));
      for (int i = 0; i < 500; i++) begin
        if ($urandom % 20 == 0) begin wr_req = 1; wr_val = CW'($urandom % (per + 2)); end
        if ($urandom % 40 == 0) upd_req = 1;
        if ($urandom % 60 == 0) ch_en_i = ~ch_en_i;
        if ($urandom % 90 == 0) cmp_mode_i = ~cmp_mode_i;
        if ($urandom % 70 == 0) tmr_en_i = ~tmr_en_i;
        if ($urandom % 80 == 0) def_level_i = ~def_level_i;
        if ($urandom % 8 == 0) begin ch_en_i = 1; cmp_mode_i = 1; end
        step();
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule